// File: doc/BRIEF.md
# Edge-Width Capture Timer with Word FIFO

This block measures how long an input signal stays between valid edges. A free-running prescaler divides the system clock by a 12-bit value to make a count tick. A 16-bit counter advances on each tick, and a filtered copy of the capture pin decides when a measurement ends. Each measurement is pushed as a 16-bit word into a small FIFO that software drains one word at a time. Bit 15 of each word is a tag and bits 14:0 hold the width in ticks.

The edge mode picks the kind of measurement. In single-edge modes (rising-to-rising or falling-to-falling) the tag marks a segment that timed out at the end value. Software adds such a segment to the next untagged word. In any-edge mode the tag tells a high-level width from a low-level width. Four sticky flags report FIFO fill, FIFO overflow, timeouts and input activity. Writing 1 to a flag clears it. A clear-all input empties the FIFO and holds the counter at zero for as long as it is high.

Top module: `edge_width_timer`

## Requirements
- R1: The count tick occurs once every D system clocks, where D is `div_val` (0 acts as 1). With D=3, two rising edges 60 clocks apart give a width of 20.
- R2: `edge_mode` selects the measurement: 2'b00 off (no words, counter held at 0), 2'b01 any edge, 2'b10 falling to falling, 2'b11 rising to rising.
- R3: In modes 2'b10/2'b11, when the counter would reach `end_val`, the word {1, end_val[14:0]} is pushed, the counter restarts at 0 and flag bit 2 (end) sets. With end 4000h, a gap of 9035h ticks yields C000h, C000h, 1035h.
- R4: A valid edge pushes {tag, count[14:0]} and restarts the count. The tag is 0 in single-edge modes. The first word after capture starts measures from the start time.
- R5: In mode 2'b01 the tag is 1 for a high level (ended by a falling edge) and 0 for a low level (ended by a rising edge).
- R6: The FIFO holds 8 words in arrival order. A pulse on `rd_en` with words present puts the oldest word on `rd_data` after the next clock edge. `fifo_cnt` shows the number of stored words.
- R7: A push while 8 words are stored drops the word and sets flag bit 1 (overflow).
- R8: Flag bit 0 (request) sets while the FIFO holds 4 or more words.
- R9: The flags are {act, end, ovf, req} on bits 3..0. Each bit is cleared by a 1 on the matching `flag_clr` bit unless a new set occurs in that cycle. Bit 3 sets on every valid edge while capture runs.
- R10: The filtered level changes only after the pin has held a new level for 4 consecutive ticks. Shorter pulses have no effect. When `no_min_width` is 1 and `div_val` is 1, the filter follows the synchronized pin on every clock.
- R11: While `clr_all` is high the FIFO is empty, the counter and prescaler stay at 0 and no word is pushed.
- R12: After reset `in_level` is 1, the FIFO is empty and all flags are 0.
- R13: While `cnt_en` is 0 the counter and prescaler hold, and no edge is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | 1 | Raw capture pin |
| div_val | input | 12 | Prescaler divide value |
| end_val | input | 16 | Timeout limit for single-edge modes |
| edge_mode | input | 2 | Measurement mode |
| cnt_en | input | 1 | Count enable |
| clr_all | input | 1 | Clear counter and FIFO while high |
| no_min_width | input | 1 | Bypass the pulse-width filter (effective only with divide 1) |
| rd_en | input | 1 | Pop one FIFO word |
| flag_clr | input | 4 | Write-1-to-clear strobes for the flags |
| rd_data | output | 16 | Last popped word |
| fifo_cnt | output | 4 | Number of stored words |
| flags | output | 4 | {act, end, ovf, req} |
| in_level | output | 1 | Filtered pin level |

## Verification
A wrong counter or prescaler state does not show until the next edge or timeout, when the popped width word is off. The bench therefore pops words and checks each width against an edge spacing it has computed. A corrupt FIFO pointer or count shows on `fifo_cnt` or `rd_data` one clock after the push or pop that disturbs it. A filter fault shows on `in_level` within a few ticks of a pin change. The reference model follows the block on every clock, so any of these faults is reported in the cycle it first reaches a port.

// File: rtl/ewt_pkg.sv
package ewt_pkg;
  typedef enum logic [1:0] {
    EM_OFF  = 2'b00,
    EM_ANY  = 2'b01,
    EM_FALL = 2'b10,
    EM_RISE = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ewt_tick_div.sv
module ewt_tick_div #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div_val == '0) ? DIV_W'(1) : div_val;
  assign tick = en && !clr && (div_cnt == lim - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr) div_cnt <= '0;
    else if (en)    div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
  end
endmodule

// File: rtl/ewt_filter.sv
module ewt_filter #(
  parameter int MIN_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic tick,
  input  logic bypass,
  output logic level
);
  localparam int STW = (MIN_TICKS > 2) ? $clog2(MIN_TICKS) : 1;

  logic           s1, s2;
  logic [STW-1:0] stab;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= pin;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      stab  <= '0;
    end else if (bypass) begin
      level <= s2;
      stab  <= '0;
    end else if (tick) begin
      if (s2 == level) begin
        stab <= '0;
      end else if (stab == STW'(MIN_TICKS - 1)) begin
        level <= s2;
        stab  <= '0;
      end else begin
        stab <= stab + STW'(1);
      end
    end
  end
endmodule

// File: rtl/ewt_width_counter.sv
module ewt_width_counter
  import ewt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  edge_mode_e       mode,
  input  logic             tick,
  input  logic             level,
  input  logic [CNT_W-1:0] end_val,
  output logic             push,
  output logic [CNT_W-1:0] push_word,
  output logic             hit_edge,
  output logic             hit_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nxt;
  logic             lvl_q;
  logic             rise, fall, edge_ok, active, single;

  assign rise   = level & ~lvl_q;
  assign fall   = ~level & lvl_q;
  assign nxt    = cnt + CNT_W'(1);
  assign active = en && !clr && (mode != EM_OFF);
  assign single = (mode == EM_FALL) || (mode == EM_RISE);

  always_comb begin
    case (mode)
      EM_ANY:  edge_ok = rise | fall;
      EM_FALL: edge_ok = fall;
      EM_RISE: edge_ok = rise;
      default: edge_ok = 1'b0;
    endcase
  end

  assign hit_edge  = active && edge_ok;
  assign hit_end   = active && !edge_ok && tick && single && (nxt == end_val);
  assign push      = hit_edge || hit_end;
  assign push_word = hit_edge ? {(mode == EM_ANY) && fall, cnt[CNT_W-2:0]}
                              : {1'b1, end_val[CNT_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b1;
    else     lvl_q <= level;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || mode == EM_OFF) cnt <= '0;
    else if (en) begin
      if (push)      cnt <= '0;
      else if (tick) cnt <= nxt;
    end
  end
endmodule

// File: rtl/ewt_fifo.sv
module ewt_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign do_push = push && !clr && (count != CW'(DEPTH));
  assign do_pop  = pop && !clr && (count != '0);
  assign drop    = push && !clr && (count == CW'(DEPTH));

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (do_pop) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/edge_width_timer.sv
module edge_width_timer
  import ewt_pkg::*;
#(
  parameter int DIV_W     = 12,
  parameter int CNT_W     = 16,
  parameter int DEPTH     = 8,
  parameter int MIN_TICKS = 4,
  parameter int REQ_LEVEL = 4,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_in,
  input  logic [DIV_W-1:0] div_val,
  input  logic [CNT_W-1:0] end_val,
  input  logic [1:0]       edge_mode,
  input  logic             cnt_en,
  input  logic             clr_all,
  input  logic             no_min_width,
  input  logic             rd_en,
  input  logic [3:0]       flag_clr,
  output logic [CNT_W-1:0] rd_data,
  output logic [CW-1:0]    fifo_cnt,
  output logic [3:0]       flags,
  output logic             in_level
);
  logic             tick_w, bypass_w, push_w, hit_edge_w, hit_end_w, drop_w;
  logic [CNT_W-1:0] word_w;
  logic [3:0]       flag_set;

  assign bypass_w = no_min_width && (div_val == DIV_W'(1));

  ewt_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(clr_all), .en(cnt_en),
    .div_val(div_val), .tick(tick_w)
  );

  ewt_filter #(.MIN_TICKS(MIN_TICKS)) u_filt (
    .clk(clk), .rst(rst), .pin(cap_in), .tick(tick_w),
    .bypass(bypass_w), .level(in_level)
  );

  ewt_width_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_all), .en(cnt_en),
    .mode(edge_mode_e'(edge_mode)), .tick(tick_w), .level(in_level),
    .end_val(end_val), .push(push_w), .push_word(word_w),
    .hit_edge(hit_edge_w), .hit_end(hit_end_w)
  );

  ewt_fifo #(.DW(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr_all), .push(push_w), .wdata(word_w),
    .pop(rd_en), .rdata(rd_data), .count(fifo_cnt), .drop(drop_w)
  );

  assign flag_set = {hit_edge_w, hit_end_w, drop_w, fifo_cnt >= CW'(REQ_LEVEL)};

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~flag_clr) | flag_set;
  end
endmodule

// File: rtl/ewt_checker.sv
module ewt_checker #(
  parameter int DEPTH     = 8,
  parameter int REQ_LEVEL = 4,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clr_all,
  input logic          push,
  input logic          tick,
  input logic          bypass,
  input logic          hit_edge,
  input logic [3:0]    flag_clr,
  input logic [3:0]    flags,
  input logic [CW-1:0] fifo_cnt,
  input logic          in_level
);
  p_bound_r6: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_cnt) <= DEPTH);

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    !clr_all |=> (int'(fifo_cnt) <= int'($past(fifo_cnt)) + 1) &&
                 (int'(fifo_cnt) + 1 >= int'($past(fifo_cnt))));

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> fifo_cnt == '0);

  p_drop_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !clr_all && int'(fifo_cnt) == DEPTH) |=> flags[1]);

  p_req_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(fifo_cnt) >= REQ_LEVEL) |=> flags[0]);

  p_w1c_act_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[3] && !hit_edge) |=> !flags[3]);

  p_filter_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(tick || bypass) |=> $stable(in_level));
endmodule

bind edge_width_timer ewt_checker #(.DEPTH(DEPTH), .REQ_LEVEL(REQ_LEVEL), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .clr_all(clr_all), .push(push_w), .tick(tick_w),
  .bypass(bypass_w), .hit_edge(hit_edge_w), .flag_clr(flag_clr),
  .flags(flags), .fifo_cnt(fifo_cnt), .in_level(in_level)
);

// File: tb/tb_edge_width_timer.sv
module tb_edge_width_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_in = 1'b1;
  logic [11:0] div_val = 12'd1;
  logic [15:0] end_val = 16'h7FFF;
  logic [1:0]  edge_mode = 2'b00;
  logic        cnt_en = 1'b0;
  logic        clr_all = 1'b1;
  logic        no_min_width = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  flag_clr = 4'h0;
  logic [15:0] rd_data;
  logic [3:0]  fifo_cnt;
  logic [3:0]  flags;
  logic        in_level;

  always #5 clk = ~clk;

  edge_width_timer dut (
    .clk(clk), .rst(rst), .cap_in(cap_in), .div_val(div_val), .end_val(end_val),
    .edge_mode(edge_mode), .cnt_en(cnt_en), .clr_all(clr_all),
    .no_min_width(no_min_width), .rd_en(rd_en), .flag_clr(flag_clr),
    .rd_data(rd_data), .fifo_cnt(fifo_cnt), .flags(flags), .in_level(in_level)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string phase = "R12";
  bit    done = 0;
  logic [15:0] got;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_s1, m_s2, m_filt, m_lq;
  int          m_stab, m_div, m_cnt;
  logic [15:0] m_q[$];
  logic [15:0] m_rd;
  logic [3:0]  m_flags;
  int          lim, old_size, nxt;
  bit          tk, byp, rise, fall, edg, act, single, h_edge, h_end, drop, req_set;
  logic [15:0] word;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_filt = 1; m_lq = 1; m_stab = 0; m_div = 0; m_cnt = 0;
      m_q.delete(); m_rd = 0; m_flags = 0;
    end else begin
      lim    = (div_val == 0) ? 1 : int'(div_val);
      tk     = cnt_en && !clr_all && (m_div == lim - 1);
      byp    = no_min_width && (div_val == 1);
      rise   = m_filt && !m_lq;
      fall   = !m_filt && m_lq;
      edg    = (edge_mode == 2'b01) ? (rise || fall) :
               (edge_mode == 2'b10) ? fall : (edge_mode == 2'b11) ? rise : 1'b0;
      act    = cnt_en && !clr_all && (edge_mode != 2'b00);
      single = edge_mode[1];
      nxt    = (m_cnt + 1) & 16'hFFFF;
      h_edge = act && edg;
      h_end  = act && !edg && tk && single && (nxt == int'(end_val));
      if (h_edge) word = {(edge_mode == 2'b01) && fall, 15'(m_cnt)};
      else        word = {1'b1, end_val[14:0]};
      old_size = m_q.size();
      req_set  = old_size >= 4;
      drop     = 0;
      if (clr_all) m_q.delete();
      else begin
        if (rd_en && old_size > 0) m_rd = m_q.pop_front();
        if (h_edge || h_end) begin
          if (old_size == 8) drop = 1;
          else m_q.push_back(word);
        end
      end
      m_flags = (m_flags & ~flag_clr) | {h_edge, h_end, drop, req_set};
      if (clr_all || edge_mode == 2'b00) m_cnt = 0;
      else if (cnt_en) begin
        if (h_edge || h_end) m_cnt = 0;
        else if (tk) m_cnt = nxt;
      end
      m_lq = m_filt;
      if (byp) begin m_filt = m_s2; m_stab = 0; end
      else if (tk) begin
        if (m_s2 == m_filt) m_stab = 0;
        else if (m_stab == 3) begin m_filt = m_s2; m_stab = 0; end
        else m_stab = m_stab + 1;
      end
      m_s2 = m_s1;
      m_s1 = cap_in;
      if (clr_all) m_div = 0;
      else if (cnt_en) m_div = tk ? 0 : ((m_div + 1) & 12'hFFF);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({phase, " rd_data"}, rd_data, m_rd);
      chk({phase, " fifo_cnt"}, fifo_cnt, m_q.size());
      chk({phase, " flags"}, flags, m_flags);
      chk({phase, " in_level"}, in_level, m_filt);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(int dv, logic [1:0] md, logic [15:0] ev, bit nm);
    @(negedge clk);
    clr_all = 1;
    div_val = 12'(dv); edge_mode = md; end_val = ev; no_min_width = nm;
    wait_clk(2);
    clr_all = 0; cnt_en = 1;
  endtask

  task automatic pop_word();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    got = rd_data;
  endtask

  initial begin
    wait_clk(3);
    rst = 0;
    wait_clk(1);
    chk("R12 in_level", in_level, 1);
    chk("R12 fifo_cnt", fifo_cnt, 0);
    chk("R12 flags", flags, 0);

    // R1 / R4 / R6: rising-to-rising, divide by 3
    phase = "R1";
    cap_in = 0;
    setup(3, 2'b11, 16'h7FFF, 0);
    wait_clk(40);
    cap_in = 1; wait_clk(30); cap_in = 0; wait_clk(30);
    cap_in = 1; wait_clk(30); cap_in = 0; wait_clk(40);
    chk("R6 two words stored", fifo_cnt, 2);
    pop_word(); chk("R4 first word tag", got[15], 0);
    pop_word(); chk("R1 width 60 clocks / 3", got, 16'd20);

    // R10: short pulse rejected
    phase = "R10";
    cap_in = 1; wait_clk(6); cap_in = 0; wait_clk(40);
    chk("R10 glitch no word", fifo_cnt, 0);
    chk("R10 glitch level", in_level, 0);

    // R2: falling-to-falling
    phase = "R2";
    setup(3, 2'b10, 16'h7FFF, 0);
    cap_in = 1; wait_clk(30); cap_in = 0; wait_clk(30);
    cap_in = 1; wait_clk(30); cap_in = 0; wait_clk(40);
    chk("R2 fall mode words", fifo_cnt, 2);
    pop_word(); pop_word();
    chk("R2 fall width", got, 16'd20);

    // R2: mode off
    setup(3, 2'b00, 16'h7FFF, 0);
    cap_in = 1; wait_clk(30); cap_in = 0; wait_clk(30);
    chk("R2 off mode no words", fifo_cnt, 0);

    // R5: any edge
    phase = "R5";
    setup(1, 2'b01, 16'h7FFF, 0);
    wait_clk(10);
    cap_in = 1; wait_clk(25); cap_in = 0; wait_clk(15); cap_in = 1; wait_clk(20);
    chk("R5 any words", fifo_cnt, 3);
    pop_word();
    pop_word(); chk("R5 high width tag 1", got, 16'h8018);
    pop_word(); chk("R5 low width tag 0", got, 16'h000E);

    // R3 / R8: timeout segments
    phase = "R3";
    setup(1, 2'b11, 16'h4000, 0);
    cap_in = 0; wait_clk(20);
    cap_in = 1; wait_clk(100); cap_in = 0; wait_clk(16'h9036 - 100);
    cap_in = 1; wait_clk(20);
    chk("R3 four words", fifo_cnt, 4);
    chk("R8 request flag", flags[0], 1);
    chk("R3 end flag", flags[2], 1);
    chk("R9 act flag", flags[3], 1);
    pop_word();
    pop_word(); chk("R3 first timeout", got, 16'hC000);
    pop_word(); chk("R3 second timeout", got, 16'hC000);
    pop_word(); chk("R3 remainder", got, 16'h1035);
    phase = "R9";
    @(negedge clk); flag_clr = 4'hF;
    @(negedge clk); flag_clr = 4'h0;
    chk("R9 flags cleared", flags, 0);

    // R7 / R10 bypass: overflow with 3-clock pulses
    phase = "R7";
    setup(1, 2'b01, 16'h7FFF, 1);
    for (int i = 0; i < 12; i++) begin
      cap_in = ~cap_in; wait_clk(3);
    end
    wait_clk(10);
    chk("R7 fifo full", fifo_cnt, 8);
    chk("R7 overflow flag", flags[1], 1);
    pop_word();
    pop_word(); chk("R10 bypass short width", got[14:0], 2);

    // R13: pause
    phase = "R13";
    setup(1, 2'b11, 16'h7FFF, 0);
    cap_in = 0; wait_clk(20);
    cap_in = 1; wait_clk(10); cap_in = 0; wait_clk(10);
    cnt_en = 0; wait_clk(50); cnt_en = 1; wait_clk(10);
    cap_in = 1; wait_clk(20);
    chk("R13 words", fifo_cnt, 2);
    pop_word();
    pop_word(); chk("R13 paused width", got, 16'd29);

    // R11: clear-all
    phase = "R11";
    cap_in = 0; wait_clk(20); cap_in = 1; wait_clk(20);
    chk("R11 word before clear", fifo_cnt, 1);
    @(negedge clk); clr_all = 1;
    @(negedge clk);
    chk("R11 fifo emptied", fifo_cnt, 0);
    cap_in = 0; wait_clk(30); cap_in = 1; wait_clk(30);
    chk("R11 held empty", fifo_cnt, 0);
    clr_all = 0;
    wait_clk(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule